// File: doc/BRIEF.md
# Serial Port Failure-Policy Controller

This block sits between the outbound packet queue of a serial packet port and its link transmitter, and beside the receive path. It compares an externally maintained error-rate count with a failed-error threshold. When the count reaches the threshold while the port is not locked out, it raises a sticky failed-encountered flag. It then applies one of four output policies that software selects with two control bits. The policies are: keep sending, discard packets the link partner rejects until the count recovers, stall the queue with backpressure, or discard every outbound packet. The last two hold until software clears the flag.

The output side is a single-beat valid/ready handshake: one beat is one packet. Link-partner results arrive as a response strobe with a not-accepted qualifier. The controller answers each rejection with either a retry request or a discard indication. A lockout bit stops packet traffic in both directions and refuses every received packet. When lockout is clear, separate input-enable and output-enable bits gate each direction. A read-only port-type bit always reads 1, which marks the port as serial.

The controller is a four-state machine. RUN is normal operation. SELDROP discards rejected packets. STALL blocks the output with backpressure. DROPALL consumes and discards every packet.

The transitions are:
- RUN goes to SELDROP, STALL or DROPALL on a failure under policy 01, 10 or 11. Under policy 00 it stays in RUN.
- SELDROP goes back to RUN once the count falls below the threshold.
- STALL and DROPALL go back to RUN in the cycle after the failed-encountered flag reads 0.

Top module: `port_fail_policy`

## Requirements
- R1: After reset, sts_fail and sts_drop are 0, the state is RUN, and the output handshake passes through (ln_valid follows up_valid, up_ready follows ln_ready) when out_en is 1 and lockout is 0.
- R2: A failure exists when err_thresh is not 0 and err_cnt >= err_thresh, including equality. A failure while lockout is 0 sets sts_fail at the next clock edge. A failure while lockout is 1 does not set it.
- R3: The policy is {pol_stop, pol_drop}. With policy 00, a failure sets sts_fail but outbound packets still pass, and a not-accepted response raises rsp_retry.
- R4: With policy 01, a failure enters SELDROP. There, a response with rsp_nack=1 drives rsp_discard=1 and rsp_retry=0, and sets sts_drop at the next edge. Once err_cnt falls below err_thresh, the next edge returns to RUN, and rejections are retried again.
- R5: With policy 10, a failure enters STALL. There, ln_valid and up_ready are 0 until sts_fail is cleared, even after the count recovers. Traffic resumes one edge after sts_fail reads 0.
- R6: With policy 11, a failure enters DROPALL. There, up_ready is 1 and ln_valid is 0, and each offered packet (up_valid=1) sets sts_drop. The state holds until sts_fail is cleared.
- R7: sts_fail and sts_drop are write-1-to-clear. A pulse on clr_fail or clr_drop clears the bit at the next edge. When a set and a clear occur in the same cycle, the bit remains 1.
- R8: With lockout=1, no packet is issued (ln_valid=0, up_ready=0 outside DROPALL). Every received packet gets rx_nacc=1 and rx_acc=0.
- R9: With lockout=0, a received packet gets rx_acc=1 when in_en=1 and rx_nacc=1 when in_en=0. The output handshake is open only when out_en=1.
- R10: With err_thresh equal to 0, no count value sets sts_fail or leaves RUN.
- R11: sts_serial always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_stop | input | 1 | Policy bit 1 (stop) |
| pol_drop | input | 1 | Policy bit 0 (drop) |
| lockout | input | 1 | Stops all packet traffic |
| in_en | input | 1 | Receive enable when not locked out |
| out_en | input | 1 | Transmit enable when not locked out |
| err_cnt | input | CNT_W | Current error-rate count |
| err_thresh | input | CNT_W | Failed-error threshold, 0 disables |
| clr_fail | input | 1 | Write-1 clear of sts_fail |
| clr_drop | input | 1 | Write-1 clear of sts_drop |
| sts_fail | output | 1 | Sticky failed-encountered flag |
| sts_drop | output | 1 | Sticky packet-dropped flag |
| sts_serial | output | 1 | Port type, constant 1 |
| up_valid | input | 1 | Queue offers a packet |
| up_ready | output | 1 | Packet taken from the queue |
| ln_valid | output | 1 | Packet offered to the link |
| ln_ready | input | 1 | Link takes the packet |
| rsp_valid | input | 1 | Link-partner response strobe |
| rsp_nack | input | 1 | Response is not-accepted |
| rsp_retry | output | 1 | Rejected packet should be resent |
| rsp_discard | output | 1 | Rejected packet is discarded |
| rx_valid | input | 1 | Packet received from the link |
| rx_acc | output | 1 | Received packet accepted |
| rx_nacc | output | 1 | Received packet refused |

## Verification
The assertions assume that err_cnt, err_thresh and the control bits change only between clock edges. They also assume that the policy bits stay fixed while the machine is outside RUN, and that rsp_nack is meaningful only with rsp_valid. The bench drives every input just after the falling edge. It changes the policy only after the machine has returned to RUN and sts_fail has been cleared. It raises rsp_nack only together with rsp_valid.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SELDROP = 2'd1,
        ST_STALL   = 2'd2,
        ST_DROPALL = 2'd3
    } pol_state_e;

    typedef enum logic [1:0] {
        POL_CONT    = 2'b00,
        POL_SELDROP = 2'b01,
        POL_STALL   = 2'b10,
        POL_DROPALL = 2'b11
    } policy_e;

endpackage

// File: rtl/pfp_fail_detect.sv
module pfp_fail_detect #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] err_cnt,
    input  logic [CNT_W-1:0] err_thresh,
    output logic             fail_now
);
    localparam logic [CNT_W-1:0] DISABLED = '0;

    always_comb begin
        fail_now = (err_thresh != DISABLED) && (err_cnt >= err_thresh);
    end
endmodule

// File: rtl/pfp_sticky_w1c.sv
module pfp_sticky_w1c (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/pfp_policy_fsm.sv
module pfp_policy_fsm
    import pfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] policy,
    input  logic       fail_now,
    input  logic       lockout,
    input  logic       fail_flag,
    output pol_state_e st
);
    pol_state_e st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_RUN;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN: begin
                if (fail_now && !lockout) begin
                    unique case (policy_e'(policy))
                        POL_CONT:    st_nxt = ST_RUN;
                        POL_SELDROP: st_nxt = ST_SELDROP;
                        POL_STALL:   st_nxt = ST_STALL;
                        POL_DROPALL: st_nxt = ST_DROPALL;
                    endcase
                end
            end
            ST_SELDROP: begin
                if (!fail_now) st_nxt = ST_RUN;
            end
            ST_STALL, ST_DROPALL: begin
                if (!fail_flag) st_nxt = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/port_fail_policy.sv
module port_fail_policy
    import pfp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pol_stop,
    input  logic             pol_drop,
    input  logic             lockout,
    input  logic             in_en,
    input  logic             out_en,
    input  logic [CNT_W-1:0] err_cnt,
    input  logic [CNT_W-1:0] err_thresh,
    input  logic             clr_fail,
    input  logic             clr_drop,
    output logic             sts_fail,
    output logic             sts_drop,
    output logic             sts_serial,
    input  logic             up_valid,
    output logic             up_ready,
    output logic             ln_valid,
    input  logic             ln_ready,
    input  logic             rsp_valid,
    input  logic             rsp_nack,
    output logic             rsp_retry,
    output logic             rsp_discard,
    input  logic             rx_valid,
    output logic             rx_acc,
    output logic             rx_nacc
);
    logic       fail_now;
    logic       fail_set;
    logic       drop_evt;
    logic       tx_ok;
    logic       rx_ok;
    pol_state_e st;

    pfp_fail_detect #(.CNT_W(CNT_W)) u_det (
        .err_cnt    (err_cnt),
        .err_thresh (err_thresh),
        .fail_now   (fail_now)
    );

    pfp_policy_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .policy    ({pol_stop, pol_drop}),
        .fail_now  (fail_now),
        .lockout   (lockout),
        .fail_flag (sts_fail),
        .st        (st)
    );

    assign fail_set = fail_now && !lockout;

    pfp_sticky_w1c u_fail (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fail_set),
        .clr_i (clr_fail),
        .q     (sts_fail)
    );

    pfp_sticky_w1c u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (drop_evt),
        .clr_i (clr_drop),
        .q     (sts_drop)
    );

    assign sts_serial = 1'b1;
    assign tx_ok      = !lockout && out_en;
    assign rx_ok      = !lockout && in_en;

    always_comb begin
        rx_acc  = rx_valid && rx_ok;
        rx_nacc = rx_valid && !rx_ok;
    end

    always_comb begin
        ln_valid    = 1'b0;
        up_ready    = 1'b0;
        rsp_retry   = 1'b0;
        rsp_discard = 1'b0;
        drop_evt    = 1'b0;
        unique case (st)
            ST_RUN: begin
                ln_valid  = up_valid && tx_ok;
                up_ready  = ln_ready && tx_ok;
                rsp_retry = rsp_valid && rsp_nack;
            end
            ST_SELDROP: begin
                ln_valid    = up_valid && tx_ok;
                up_ready    = ln_ready && tx_ok;
                rsp_discard = rsp_valid && rsp_nack;
                drop_evt    = rsp_valid && rsp_nack;
            end
            ST_STALL: begin
                ln_valid = 1'b0;
                up_ready = 1'b0;
            end
            ST_DROPALL: begin
                up_ready = 1'b1;
                drop_evt = up_valid;
            end
        endcase
    end
endmodule

// File: rtl/port_fail_policy_chk.sv
module port_fail_policy_chk
    import pfp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lockout,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] err_thresh,
    input logic             clr_drop,
    input logic             sts_fail,
    input logic             sts_drop,
    input logic             up_ready,
    input logic             ln_valid,
    input logic             rsp_retry,
    input logic             rsp_discard,
    input logic             rx_valid,
    input logic             rx_acc,
    input logic             rx_nacc,
    input pol_state_e       st
);
    // R2
    fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_thresh != '0 && err_cnt >= err_thresh && !lockout) |=> sts_fail);

    // R10
    zero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_thresh == '0 && !sts_fail) |=> !sts_fail);

    // R7
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_drop && !clr_drop) |=> sts_drop);

    // R5
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STALL) |-> (!ln_valid && !up_ready));

    // R6
    dropall_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DROPALL) |-> (!ln_valid && up_ready));

    // R4
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_retry && rsp_discard));

    // R8
    lockout_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && rx_valid) |-> (rx_nacc && !rx_acc));
endmodule

bind port_fail_policy port_fail_policy_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lockout     (lockout),
    .err_cnt     (err_cnt),
    .err_thresh  (err_thresh),
    .clr_drop    (clr_drop),
    .sts_fail    (sts_fail),
    .sts_drop    (sts_drop),
    .up_ready    (up_ready),
    .ln_valid    (ln_valid),
    .rsp_retry   (rsp_retry),
    .rsp_discard (rsp_discard),
    .rx_valid    (rx_valid),
    .rx_acc      (rx_acc),
    .rx_nacc     (rx_nacc),
    .st          (st)
);

// File: tb/sim_port_fail_policy.sv
`timescale 1ns/1ps
module sim_port_fail_policy;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pol_stop = 0, pol_drop = 0, lockout = 0, in_en = 1, out_en = 1;
    logic [CNT_W-1:0] err_cnt = '0, err_thresh = '0;
    logic clr_fail = 0, clr_drop = 0;
    logic sts_fail, sts_drop, sts_serial;
    logic up_valid = 0, up_ready, ln_valid, ln_ready = 0;
    logic rsp_valid = 0, rsp_nack = 0, rsp_retry, rsp_discard;
    logic rx_valid = 0, rx_acc, rx_nacc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    port_fail_policy #(.CNT_W(CNT_W)) u0 (.*);

    // {lockout,in_en,out_en,up_valid,ln_ready,rx_valid, ln_valid,up_ready,rx_acc,rx_nacc}
    localparam logic [9:0] VEC [8] = '{
        10'b011111_1110,
        10'b011100_1000,
        10'b011011_0110,
        10'b001111_1101,
        10'b010111_0010,
        10'b111111_0001,
        10'b100001_0001,
        10'b000000_0000
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr(input bit f, input bit d);
        clr_fail = f;
        clr_drop = d;
        tick();
        clr_fail = 0;
        clr_drop = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        tick();

        chk("R1 sts_fail", sts_fail, 0);
        chk("R1 sts_drop", sts_drop, 0);
        chk("R11 serial", sts_serial, 1);
        up_valid = 1; ln_ready = 1;
        #1 chk("R1 pass ln_valid", ln_valid, 1);
        chk("R1 pass up_ready", up_ready, 1);

        // R8 R9: table walk, no failure pending
        for (int i = 0; i < 8; i++) begin
            {lockout, in_en, out_en, up_valid, ln_ready, rx_valid} = VEC[i][9:4];
            #1;
            chk($sformatf("R8/R9 vec%0d", i), {ln_valid, up_ready, rx_acc, rx_nacc}, VEC[i][3:0]);
        end
        lockout = 0; in_en = 1; out_en = 1; up_valid = 1; ln_ready = 1; rx_valid = 0;
        tick();

        // R10: zero threshold disables
        err_thresh = 0; err_cnt = 8'hFF; pol_stop = 1; pol_drop = 0;
        tick(); tick();
        chk("R10 no fail", sts_fail, 0);
        chk("R10 still running", ln_valid, 1);

        // R3 / R2: policy 00, count equal to threshold
        pol_stop = 0; pol_drop = 0;
        err_thresh = 4; err_cnt = 4;
        tick();
        chk("R2 fail set at equal", sts_fail, 1);
        chk("R3 keeps sending", ln_valid, 1);
        rsp_valid = 1; rsp_nack = 1;
        #1 chk("R3 retry", rsp_retry, 1);
        rsp_valid = 0; rsp_nack = 0;

        // R7: clear, then set and clear together
        err_cnt = 0;
        pulse_clr(1, 0);
        chk("R7 fail cleared", sts_fail, 0);
        err_cnt = 4;
        pulse_clr(1, 0);
        chk("R7 set wins over clear", sts_fail, 1);
        err_cnt = 0;
        pulse_clr(1, 0);
        chk("R7 fail cleared again", sts_fail, 0);

        // R4: policy 01
        pol_drop = 1;
        err_cnt = 5;
        tick();
        rsp_valid = 1; rsp_nack = 1;
        #1 chk("R4 discard", rsp_discard, 1);
        chk("R4 no retry", rsp_retry, 0);
        tick();
        rsp_valid = 0; rsp_nack = 0;
        chk("R4 drop flag", sts_drop, 1);
        err_cnt = 3;
        tick();
        rsp_valid = 1; rsp_nack = 1;
        #1 chk("R4 recovered retry", rsp_retry, 1);
        chk("R4 recovered no discard", rsp_discard, 0);
        rsp_valid = 0; rsp_nack = 0;
        pulse_clr(1, 1);
        chk("R7 drop cleared", sts_drop, 0);
        chk("R7 fail cleared p01", sts_fail, 0);

        // R5: policy 10
        pol_stop = 1; pol_drop = 0;
        err_cnt = 4;
        tick();
        chk("R5 stall ln_valid", ln_valid, 0);
        chk("R5 stall up_ready", up_ready, 0);
        err_cnt = 0;
        tick(); tick(); tick();
        chk("R5 still stalled", {ln_valid, up_ready}, 2'b00);
        pulse_clr(1, 0);
        tick();
        chk("R5 resumes", {ln_valid, up_ready}, 2'b11);

        // R6: policy 11
        pol_stop = 1; pol_drop = 1;
        ln_ready = 0;
        err_cnt = 9;
        tick();
        chk("R6 up_ready", up_ready, 1);
        chk("R6 no ln_valid", ln_valid, 0);
        tick();
        chk("R6 drop flag", sts_drop, 1);
        err_cnt = 0;
        pulse_clr(0, 1);
        tick();
        chk("R6 holds until fail clear", {ln_valid, up_ready}, 2'b01);
        chk("R6 drop set again", sts_drop, 1);
        pulse_clr(1, 1);
        tick();
        ln_ready = 1;
        #1 chk("R6 back to run", {ln_valid, up_ready}, 2'b11);

        // R2: lockout masks failure
        pulse_clr(0, 1);
        lockout = 1; pol_stop = 1; pol_drop = 0;
        err_cnt = 4;
        tick(); tick();
        chk("R2 lockout masks fail", sts_fail, 0);
        rx_valid = 1;
        #1 chk("R8 refuse", {rx_acc, rx_nacc}, 2'b01);
        chk("R8 no issue", {ln_valid, up_ready}, 2'b00);
        rx_valid = 0; err_cnt = 0; lockout = 0;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule